// File: doc/BRIEF.md
# Dual-Word Pixel Fetch Serializer

This block sits between a 16-bit video memory data bus and a 4-bit colour output. Its input is the pixel clock. It divides that clock by two to make the display controller clock. It drives an active-low strobe that tells the board when to latch the memory bus into a 16-bit holding register. It then moves each captured word into four colour-plane shift registers, which put out one 4-bit pixel per pixel clock. A blanking input forces the colour output to zero.

A memory cycle is the span between two loads of the shift registers. In normal mode it is four pixel clocks long and carries one word. In wide mode it is eight pixel clocks long and carries two words. The two words are captured two pixel clocks apart into the same holding register. The first word goes into the shift registers on the pixel clock right after it is captured, so the register is free for the second word. The second word is loaded at the exact clock when the fourth pixel of the first word has been shown. A board configuration bit selects wide mode. The block samples that bit only at the end of a memory cycle.

The phase is the pixel-clock count within a memory cycle. Phase 0 is the first clock after reset is released, and phase 0 follows the last phase of each cycle.

Top module: `pixel_fetch_serializer`

## Requirements
- R1: `ctrl_clk` is 0 during reset and toggles on every pixel clock rising edge after reset, so it runs at half the pixel clock.
- R2: While reset is held, `pix_out` is 0, `hold_load_n` is 1 and `ctrl_clk` is 0.
- R3: In normal mode a memory cycle is phases 0 to 3. `hold_load_n` is low only in phase 2, and `mem_data` is captured at the end of that phase. The captured word reaches the shift registers at the end of phase 3.
- R4: A loaded word is shown over the next four pixel clocks, most significant pixel first: bits [15:12], then [11:8], then [7:4], then [3:0]. Output bit n is supplied by colour plane shift register n.
- R5: In wide mode a memory cycle is phases 0 to 7. `hold_load_n` is low in phase 2 and in phase 4, so it pulses twice per cycle. The holding register changes only at the end of a low-strobe phase.
- R6: In wide mode the word captured in phase 2 is loaded into the shift registers at the end of phase 3. The word captured in phase 4 is loaded at the end of phase 7. The eight pixels follow one another with no gap.
- R7: `wide_en` is sampled only at the end of the last phase of a memory cycle. Its new value governs the next cycle from phase 0.
- R8: While `blank_in` is 1, `pix_out` is 0 in the same cycle, whatever the shift registers hold. Shifting continues underneath.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wide_en | input | 1 | 1 selects two-word memory cycles; sampled at cycle end |
| mem_data | input | 16 | Video memory data bus, four packed 4-bit pixels |
| blank_in | input | 1 | Blanking; forces colour output to zero |
| ctrl_clk | output | 1 | Display controller clock, pixel clock divided by two |
| hold_load_n | output | 1 | Active-low holding-register capture strobe |
| pix_out | output | 4 | Current pixel colour |

## Verification
The strobe and the controller clock are registered-phase decodes, so each one is due in the cycle after the edge that sets the phase. A word driven in a low-strobe phase appears on `pix_out` two edges after its capture when it is the first word of a cycle. A second wide-mode word appears four edges after its capture. The blanking mask acts within the same cycle. The bench keeps its own phase, mode, holding word and output word, and advances them once for each rising edge using the inputs it drove before that edge. Each comparison is made at the falling edge, after that model step, and before the next inputs are applied.

// File: rtl/pfs_pkg.sv
package pfs_pkg;
  localparam int PIX_BITS_D  = 4;
  localparam int PIX_WORD_D  = 4;

  // last phase of a memory cycle for a given mode
  function automatic int last_phase(input int pix_per_word, input logic wide);
    return wide ? (2 * pix_per_word - 1) : (pix_per_word - 1);
  endfunction

  // index of the word bit that feeds shift-slot `slot` of plane `plane`
  function automatic int slot_bit(input int pix_bits, input int slot, input int plane);
    return slot * pix_bits + plane;
  endfunction
endpackage

// File: rtl/pfs_clk_div.sv
module pfs_clk_div (
  input  logic clk,
  input  logic rst_n,
  output logic ctrl_clk
);
  logic div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= 1'b0;
    else        div_q <= ~div_q;
  end

  assign ctrl_clk = div_q;

  AST_CTRL_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (ctrl_clk != $past(ctrl_clk))); // R1
endmodule

// File: rtl/pfs_sequencer.sv
module pfs_sequencer #(
  parameter int PIX_WORD = pfs_pkg::PIX_WORD_D,
  localparam int WIDE_LEN = 2 * PIX_WORD,
  localparam int PH_W     = $clog2(WIDE_LEN),
  localparam int CAP_A    = PIX_WORD - 2,
  localparam int LOAD_A   = PIX_WORD - 1,
  localparam int CAP_B    = PIX_WORD,
  localparam int LOAD_B   = WIDE_LEN - 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wide_en,
  output logic            wide_q,
  output logic            cap_evt,
  output logic            load_evt
);
  logic [PH_W-1:0] phase;
  logic            wrap_evt;

  assign wrap_evt = (int'(phase) == pfs_pkg::last_phase(PIX_WORD, wide_q));
  assign cap_evt  = (int'(phase) == CAP_A) || (wide_q && int'(phase) == CAP_B);
  assign load_evt = (int'(phase) == LOAD_A) || (wide_q && int'(phase) == LOAD_B);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= '0;
      wide_q <= 1'b0;
    end else if (wrap_evt) begin
      phase  <= '0;
      wide_q <= wide_en;
    end else begin
      phase  <= phase + 1'b1;
    end
  end

  AST_STROBES_APART: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cap_evt, load_evt})); // R5
  AST_NORMAL_LOAD_FOLLOWS_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && load_evt && !wide_q) |-> $past(cap_evt)); // R3
  AST_MODE_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && wide_q != $past(wide_q)) |-> (phase == '0)); // R7
endmodule

// File: rtl/pfs_hold_reg.sv
module pfs_hold_reg #(
  parameter int WORD_W = pfs_pkg::PIX_BITS_D * pfs_pkg::PIX_WORD_D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_evt,
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] hold_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_q <= '0;
    else if (cap_evt) hold_q <= din;
  end

  AST_HOLD_ONLY_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(cap_evt)) |-> $stable(hold_q)); // R5
endmodule

// File: rtl/pfs_plane_shifter.sv
module pfs_plane_shifter #(
  parameter int PIX_BITS = pfs_pkg::PIX_BITS_D,
  parameter int PIX_WORD = pfs_pkg::PIX_WORD_D,
  localparam int WORD_W  = PIX_BITS * PIX_WORD
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_evt,
  input  logic [WORD_W-1:0]   word,
  output logic [PIX_BITS-1:0] pix_raw
);
  for (genvar g = 0; g < PIX_BITS; g++) begin : g_plane
    logic [PIX_WORD-1:0] plane_q;
    logic [PIX_WORD-1:0] plane_d;

    always_comb begin
      for (int s = 0; s < PIX_WORD; s++)
        plane_d[s] = word[pfs_pkg::slot_bit(PIX_BITS, s, g)];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        plane_q <= '0;
      else if (load_evt) plane_q <= plane_d;
      else               plane_q <= {plane_q[PIX_WORD-2:0], 1'b0};
    end

    assign pix_raw[g] = plane_q[PIX_WORD-1];
  end
endmodule

// File: rtl/pixel_fetch_serializer.sv
module pixel_fetch_serializer #(
  parameter int PIX_BITS = pfs_pkg::PIX_BITS_D,
  parameter int PIX_WORD = pfs_pkg::PIX_WORD_D,
  localparam int WORD_W  = PIX_BITS * PIX_WORD
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wide_en,
  input  logic [WORD_W-1:0]   mem_data,
  input  logic                blank_in,
  output logic                ctrl_clk,
  output logic                hold_load_n,
  output logic [PIX_BITS-1:0] pix_out
);
  logic              wide_q;
  logic              cap_evt;
  logic              load_evt;
  logic [WORD_W-1:0] hold_q;
  logic [PIX_BITS-1:0] pix_raw;

  pfs_clk_div u_div (.clk(clk), .rst_n(rst_n), .ctrl_clk(ctrl_clk));

  pfs_sequencer #(.PIX_WORD(PIX_WORD)) u_seq (
    .clk(clk), .rst_n(rst_n), .wide_en(wide_en),
    .wide_q(wide_q), .cap_evt(cap_evt), .load_evt(load_evt));

  pfs_hold_reg #(.WORD_W(WORD_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .cap_evt(cap_evt), .din(mem_data), .hold_q(hold_q));

  pfs_plane_shifter #(.PIX_BITS(PIX_BITS), .PIX_WORD(PIX_WORD)) u_shift (
    .clk(clk), .rst_n(rst_n), .load_evt(load_evt), .word(hold_q), .pix_raw(pix_raw));

  assign hold_load_n = ~cap_evt;
  assign pix_out     = blank_in ? '0 : pix_raw;

  AST_WIDE_TWO_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && wide_q && $past(wide_q) && !hold_load_n && !$past(hold_load_n))
      |-> 1'b0); // R5
endmodule

// File: tb/pixel_fetch_serializer_bench.sv
module pixel_fetch_serializer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wide_en = 1'b0;
  logic [15:0] mem_data = '0;
  logic        blank_in = 1'b0;
  logic        ctrl_clk;
  logic        hold_load_n;
  logic [3:0]  pix_out;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pixel_fetch_serializer u_pixel_fetch_serializer (
    .clk(clk), .rst_n(rst_n), .wide_en(wide_en), .mem_data(mem_data),
    .blank_in(blank_in), .ctrl_clk(ctrl_clk), .hold_load_n(hold_load_n),
    .pix_out(pix_out));

  // reference state
  int          m_phase = 0;
  bit          m_wide  = 1'b0;
  bit          m_cc    = 1'b0;
  logic [15:0] m_hold  = '0;
  logic [15:0] m_out   = '0;
  int          since_switch = 100;

  function automatic bit strobe_due(input int ph, input bit wide);
    return (ph == 2) || (wide && ph == 4);
  endfunction

  function automatic bit load_due(input int ph, input bit wide);
    return (ph == 3) || (wide && ph == 7);
  endfunction

  function automatic logic [3:0] expect_pix(input logic [15:0] w, input bit blank);
    return blank ? 4'h0 : w[15:12];
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic model_step();
    bit cap, ld;
    cap = strobe_due(m_phase, m_wide);
    ld  = load_due(m_phase, m_wide);
    m_out = ld ? m_hold : {m_out[11:0], 4'h0};
    if (cap) m_hold = mem_data;
    m_cc = ~m_cc;
    if (m_phase == (m_wide ? 7 : 3)) begin
      if (m_wide != wide_en) since_switch = 0;
      m_phase = 0;
      m_wide = wide_en;
    end else begin
      m_phase++;
    end
    if (since_switch < 100) since_switch++;
  endtask

  task automatic compare_all();
    string rs, rp;
    rs = (since_switch <= 8) ? "R7" : (m_wide ? "R5" : "R3");
    if (blank_in)            rp = "R8";
    else if (since_switch <= 8) rp = "R7";
    else if (m_wide)         rp = "R6";
    else                     rp = "R4";
    check("R1", {15'd0, ctrl_clk}, {15'd0, m_cc});
    check(rs, {15'd0, hold_load_n}, {15'd0, !strobe_due(m_phase, m_wide)});
    check(rp, {12'd0, pix_out}, {12'd0, expect_pix(m_out, blank_in)});
  endtask

  // one cycle: drive inputs at falling edge, model the rising edge, compare at next falling edge
  task automatic run_cycle(input logic [15:0] d, input bit blank, input bit wide);
    mem_data = d;
    blank_in = blank;
    wide_en  = wide;
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : stimulus
    int seed;
    bit wsel;
    seed = 32'h5eed_7220;
    void'($urandom(seed));
    // R2: reset values
    mem_data = 16'hFFFF;
    blank_in = 1'b0;
    repeat (3) begin
      @(negedge clk);
      check("R2", {12'd0, pix_out}, 16'h0);
      check("R2", {15'd0, hold_load_n}, 16'h1);
      check("R2", {15'd0, ctrl_clk}, 16'h0);
    end
    rst_n = 1'b1;
    // directed normal-mode word: R4 ordering A,5,C,3
    for (int i = 0; i < 16; i++) run_cycle(16'hA5C3, 1'b0, 1'b0);
    // directed wide mode with distinct words per strobe: R6
    for (int i = 0; i < 40; i++) run_cycle(16'h1000 + 16'(i) * 16'h0111, 1'b0, 1'b1);
    // blanking over a loaded word: R8
    for (int i = 0; i < 8; i++) run_cycle(16'hFFFF, 1'b1, 1'b1);
    for (int i = 0; i < 8; i++) run_cycle(16'hFFFF, 1'b0, 1'b0);
    // random mix with mode toggling mid-cycle: R7
    wsel = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      if (($urandom() % 37) == 0) wsel = ~wsel;
      run_cycle(16'($urandom()), ($urandom() % 8) == 0, wsel);
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule